// File: doc/BRIEF.md
# Output Change-Flag Register Bank

This block sits beside a design under test and samples its output ports into registers that a host can read. Each port has its own capture register and a change detector. When a port is captured with a value that differs from the one it last held, a sticky flag for that port is set. The flags of all ports are packed into words as wide as the host bus. The host reads those words first, then reads only the ports whose flags are set. A full pass therefore costs the flag words plus one read for each changed port.

Ports are captured only in cycles where the design's clock enable is high. The host reads through a request channel and a response channel, both valid/ready. A request carries a word address and is accepted when `req_valid` and `req_ready` are both high. The response is registered, appears one cycle after acceptance, and stays unchanged while `rsp_ready` is low. `req_ready` is low while a response is waiting and `rsp_ready` is low, so at most one response is ever pending. A flag word read does not change any state. A port read clears that port's flag.

Top module: `outmon_bank`

## Requirements
- R1: After reset, all flags are clear, all captured values read as zero, `rsp_valid` is low and `req_ready` is high.
- R2: A port's captured value changes only on a cycle with `cap_en` high. With `cap_en` low, changes on `dut_out` have no effect on captured values or flags.
- R3: On a capture where a port's new value differs from its held value, that port's flag is set. A capture of an equal value leaves the flag unchanged.
- R4: Flag word k sits at address k, for k from 0 to ceil(NUM_PORTS/BUS_W)-1. Bit b of word k is the flag of port k*BUS_W+b. Bits with no port behind them read as zero.
- R5: Port i sits at address FLAG_WORDS+i. Reading it returns the captured value in the low PORT_W bits, with the upper bits zero, and clears the port's flag.
- R6: If a port read is accepted in the same cycle that port captures a changed value, the flag remains set.
- R7: Reading a flag word changes no flag.
- R8: The response appears one cycle after acceptance. It holds its valid and data while `rsp_ready` is low. No new request is accepted while it is held.
- R9: A read of an address past the last port returns zero and changes no flag.
- R10: A port read accepted in a capture cycle returns the value held before that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_en | input | 1 | Design clock enable; outputs are captured when high |
| dut_out | input | NUM_PORTS*PORT_W | Design outputs, port i at bits [i*PORT_W +: PORT_W] |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request ready |
| req_addr | input | ADDR_W | Word address of the read |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | BUS_W | Read response data |

## Verification
A wrong flag bit shows up on the next flag-word read as a port that is reported but unchanged, or changed but not reported. It also shows up as a mismatch in the following port read, one cycle after that read's acceptance. A capture register that loads at the wrong time returns a stale or early value on the next port read. That case is covered in particular by the read accepted together with a capture, and by capture with `cap_en` low. A fault in the response holding logic shows during a stall as changing data, or as a second request being accepted, within the same cycle.

// File: rtl/outmon_pkg.sv
package outmon_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_PORT = 2'd2
  } sel_kind_e;

  function automatic int unsigned div_up(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned idx_bits(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m <= 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/outmon_port_cell.sv
module outmon_port_cell #(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [PORT_W-1:0] din,
  input  logic              rd_clr,
  output logic [PORT_W-1:0] q,
  output logic              flag
);

  logic differs;
  logic changed;

  assign differs = (din != q);
  assign changed = cap_en & differs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (cap_en) begin
      q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (changed) begin
      flag <= 1'b1;
    end else if (rd_clr) begin
      flag <= 1'b0;
    end
  end

  a_r2_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(q));

  a_r3_set_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && din != q) |=> (flag && q == $past(din)));

  a_r3_quiet_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !(cap_en && din != q)) |=> !flag);

  a_r5_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !(cap_en && din != q)) |=> !flag);

  a_r6_change_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && cap_en && din != q) |=> flag);

endmodule

// File: rtl/outmon_decode.sv
module outmon_decode
  import outmon_pkg::*;
#(
  parameter int NUM_PORTS  = 6,
  parameter int FLAG_WORDS = 2,
  parameter int ADDR_W     = 4,
  parameter int IDX_W      = 3
) (
  input  logic [ADDR_W-1:0]    addr,
  output sel_kind_e            kind,
  output logic [IDX_W-1:0]     idx,
  output logic [NUM_PORTS-1:0] port_sel
);

  localparam logic [ADDR_W:0] FLAG_LIM = (ADDR_W+1)'(FLAG_WORDS);
  localparam logic [ADDR_W:0] PORT_LIM = (ADDR_W+1)'(FLAG_WORDS + NUM_PORTS);

  logic [ADDR_W:0] addr_x;
  logic [ADDR_W:0] port_off;

  assign addr_x   = {1'b0, addr};
  assign port_off = addr_x - FLAG_LIM;

  always_comb begin
    kind = SEL_NONE;
    idx  = '0;
    if (addr_x < FLAG_LIM) begin
      kind = SEL_FLAG;
      idx  = IDX_W'(addr_x);
    end else if (addr_x < PORT_LIM) begin
      kind = SEL_PORT;
      idx  = IDX_W'(port_off);
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sel
    assign port_sel[p] = (kind == SEL_PORT) && (idx == IDX_W'(p));
  end

endmodule

// File: rtl/outmon_rsp.sv
module outmon_rsp #(
  parameter int BUS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUS_W-1:0] word,
  input  logic             rsp_ready,
  output logic             rsp_valid,
  output logic [BUS_W-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

endmodule

// File: rtl/outmon_bank.sv
module outmon_bank
  import outmon_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int PORT_W    = 4,
  parameter int BUS_W     = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cap_en,
  input  logic [NUM_PORTS*PORT_W-1:0] dut_out,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [BUS_W-1:0]            rsp_data
);

  localparam int FLAG_WORDS = int'(div_up(NUM_PORTS, BUS_W));
  localparam int FLAG_BITS  = FLAG_WORDS * BUS_W;
  localparam int IDX_W      = int'(idx_bits(NUM_PORTS, FLAG_WORDS));

  logic                 req_fire;
  sel_kind_e            kind;
  logic [IDX_W-1:0]     idx;
  logic [NUM_PORTS-1:0] port_sel;
  logic [NUM_PORTS-1:0] flags;
  logic [FLAG_BITS-1:0] flags_pad;
  logic [PORT_W-1:0]    cap_q [NUM_PORTS];
  logic [BUS_W-1:0]     word;

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  outmon_decode #(
    .NUM_PORTS (NUM_PORTS),
    .FLAG_WORDS(FLAG_WORDS),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W)
  ) u_decode (
    .addr    (req_addr),
    .kind    (kind),
    .idx     (idx),
    .port_sel(port_sel)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    outmon_port_cell #(.PORT_W(PORT_W)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .cap_en(cap_en),
      .din   (dut_out[p*PORT_W +: PORT_W]),
      .rd_clr(req_fire && port_sel[p]),
      .q     (cap_q[p]),
      .flag  (flags[p])
    );
  end

  if (FLAG_BITS > NUM_PORTS) begin : g_pad
    assign flags_pad = {{(FLAG_BITS-NUM_PORTS){1'b0}}, flags};
  end else begin : g_nopad
    assign flags_pad = flags;
  end

  always_comb begin
    word = '0;
    if (kind == SEL_FLAG) begin
      for (int w = 0; w < FLAG_WORDS; w++) begin
        if (idx == IDX_W'(w)) word = flags_pad[w*BUS_W +: BUS_W];
      end
    end else if (kind == SEL_PORT) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (port_sel[p]) word[PORT_W-1:0] = cap_q[p];
      end
    end
  end

  outmon_rsp #(.BUS_W(BUS_W)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (req_fire),
    .word     (word),
    .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  a_r9_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && kind == SEL_NONE) |=> (rsp_valid && rsp_data == '0));

  a_r7_flag_read_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && kind == SEL_FLAG && !cap_en) |=> $stable(flags));

  a_r8_response_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> rsp_valid);

endmodule

// File: tb/outmon_bank_tb.sv
module outmon_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 6;
  localparam int PW = 4;
  localparam int BW = 4;
  localparam int AW = 4;
  localparam int FW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cap_en = 1'b0;
  logic [NP*PW-1:0] dut_out = '0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [AW-1:0]   req_addr = '0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [BW-1:0]   rsp_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [PW-1:0] m_cap [NP];
  logic          m_flag [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  outmon_bank #(.NUM_PORTS(NP), .PORT_W(PW), .BUS_W(BW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .dut_out(dut_out),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] model_read(input int a);
    logic [BW-1:0] w;
    w = '0;
    if (a < FW) begin
      for (int b = 0; b < BW; b++)
        if (a*BW + b < NP) w[b] = m_flag[a*BW + b];
    end else if (a < FW + NP) begin
      w = m_cap[a - FW];
    end
    return w;
  endfunction

  task automatic step(input bit ce, input logic [NP*PW-1:0] vec, input bit rv, input int a, input string req);
    logic [BW-1:0] e;
    @(negedge clk);
    cap_en = ce; dut_out = vec; req_valid = rv; req_addr = AW'(a);
    e = model_read(a);
    @(posedge clk);
    if (rv && a >= FW && a < FW + NP) m_flag[a - FW] = 1'b0;
    if (ce) begin
      for (int p = 0; p < NP; p++) begin
        if (vec[p*PW +: PW] != m_cap[p]) begin
          m_flag[p] = 1'b1;
          m_cap[p]  = vec[p*PW +: PW];
        end
      end
    end
    @(negedge clk);
    cap_en = 1'b0; req_valid = 1'b0;
    if (rv) begin
      check(rsp_valid == 1'b1, {req, " rsp_valid"}, int'(rsp_valid), 1);
      check(rsp_data == e, {req, " data"}, int'(rsp_data), int'(e));
    end
  endtask

  task automatic rd(input int a, input string req);
    step(1'b0, dut_out, 1'b1, a, req);
  endtask

  function automatic logic [NP*PW-1:0] pattern(input int s);
    logic [NP*PW-1:0] v;
    for (int p = 0; p < NP; p++)
      v[p*PW +: PW] = PW'(((s * (p + 1)) >> 1) + p);
    return v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog expired actual=%0d expected=done", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NP*PW-1:0] v;
    logic [BW-1:0] e1, e2;
    for (int p = 0; p < NP; p++) begin m_cap[p] = '0; m_flag[p] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
    check(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
    for (int a = 0; a < FW + NP; a++) rd(a, "R1 reset read");

    // R2: no capture without enable
    step(1'b0, '1, 1'b0, 0, "R2");
    for (int a = 0; a < FW + NP; a++) rd(a, "R2 disabled capture");

    // R3 R4 R5 R7: sweep of patterns, host reads flags then changed ports
    for (int s = 0; s < 48; s++) begin
      v = pattern(s);
      step(1'b1, v, 1'b0, 0, "R3");
      if (s % 3 == 0) step(1'b1, v, 1'b0, 0, "R3 repeat");
      for (int a = 0; a < FW; a++) rd(a, "R4 flag word");
      for (int a = 0; a < FW; a++) rd(a, "R7 flag reread");
      for (int p = 0; p < NP; p++)
        if (m_flag[p] || (s % 5 == 0)) rd(FW + p, "R5 port read");
      for (int a = 0; a < FW; a++) rd(a, "R5 flags after clear");
    end

    // R6 R10: read and changed capture in same cycle
    v = dut_out;
    v[PW-1:0] = v[PW-1:0] ^ 4'h5;
    step(1'b1, v, 1'b0, 0, "R6 setup");
    v[PW-1:0] = v[PW-1:0] ^ 4'h3;
    step(1'b1, v, 1'b1, FW, "R10 old value on same-cycle capture");
    check(m_flag[0] == 1'b1, "R6 model flag kept", int'(m_flag[0]), 1);
    rd(0, "R6 flag still set");
    rd(FW, "R5 read new value");
    rd(0, "R5 flag cleared");
    step(1'b1, v, 1'b1, FW + 1, "R3 equal capture with read");
    rd(0, "R3 no set on equal");

    // R9: addresses past the last port
    v = dut_out ^ {NP{4'h9}};
    step(1'b1, v, 1'b0, 0, "R9 setup");
    for (int a = FW + NP; a < (1 << AW); a++) rd(a, "R9 outside address");
    for (int a = 0; a < FW; a++) rd(a, "R9 flags untouched");

    // R8: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = AW'(FW + 2);
    e1 = model_read(FW + 2);
    @(posedge clk);
    m_flag[2] = 1'b0;
    @(negedge clk);
    req_addr = AW'(FW + 4);
    for (int k = 0; k < 3; k++) begin
      check(rsp_valid == 1'b1, "R8 valid held", int'(rsp_valid), 1);
      check(rsp_data == e1, "R8 data held", int'(rsp_data), int'(e1));
      check(req_ready == 1'b0, "R8 request blocked", int'(req_ready), 0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    e2 = model_read(FW + 4);
    @(posedge clk);
    m_flag[4] = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, "R8 second response", int'(rsp_valid), 1);
    check(rsp_data == e2, "R8 second data", int'(rsp_data), int'(e2));
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8 response drained", int'(rsp_valid), 0);
    for (int a = 0; a < FW; a++) rd(a, "R5 flags after stalled reads");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule